// File: doc/BRIEF.md
# Ring Buffer Audio DMA Channel with Section Trigger

This block is one audio DMA channel. It moves data between a ring buffer in system memory and a serial audio slot, one 32-byte chunk per transfer. Software programs a 32-bit control word and drives two static configuration pins: transfer direction and sample width. In the output direction the hardware advances the read pointer while software moves the write pointer. In the input direction the hardware advances the write pointer while software moves the read pointer. Each pointer counts chunks.

The slot side also works a whole chunk at a time. In the output direction a pull strobe takes the next fetched chunk. In the input direction a push strobe hands the channel a captured chunk. In 8-bit mode the top bit of every byte is inverted as data passes through. Each time the hardware pointer advances, the channel compares the new value with a trigger pointer under a power-of-two mask. This divides the ring into equal sections and gives a one-cycle interrupt pulse per section. A pull that finds nothing fetched is reported as underflow. A push that finds the previous chunk still unwritten is reported as overflow.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset the control word reads 0, no memory request is raised, the slot output is 0 and the trigger, overflow and underflow outputs are low.
- R2: The control word reads back as reset flag 0 in bit 31, size in bits 30:28, enable in bit 27, trigger mask select in bits 26:24, trigger pointer in bits 23:16, read pointer in bits 15:8 and write pointer in bits 7:0. A write with bit 31 set clears every field. A write stores the software-owned pointer. The hardware-owned pointer field of a write is ignored.
- R3: In the output direction with enable set, while no chunk is held and the read pointer differs from the write pointer, the channel raises a read request (memWrite low). The request address is baseWord*256 + readPointer*32. When the request is acknowledged, the returned chunk is stored and the read pointer advances.
- R4: In the input direction a pushed chunk is written (memWrite high) to baseWord*256 + writePointer*32, and the write pointer advances on acknowledge. No write is requested while the advanced write pointer would equal the read pointer.
- R5: With cfgWide low, every byte is XORed with 0x80 in both directions. With cfgWide high, data passes unchanged.
- R6: The hardware pointer wraps modulo 2^(size+1) chunks, so size 2 gives 8 chunks and size 7 gives 256 chunks.
- R7: trigIrq pulses for one cycle right after a hardware pointer advance when (newPointer & M) == (triggerPointer & M), where M = 0xFF >> maskSelect. It never pulses without an advance.
- R8: In the output direction slotData is 0 while enable is clear. A pull with a chunk held presents that chunk from the next cycle on. A pull with nothing held pulses underflowFlag and keeps the previous chunk on slotData.
- R9: A push arriving while an earlier chunk is still waiting to be written pulses overflowFlag and the new chunk is dropped.
- R10: A control write with enable clear and both pointer fields zero zeroes the hardware pointer, discards any held chunk and zeroes the slot output history.
- R11: With enable clear no memory request is raised and pulls and pushes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlWdata | input | 32 | Control word write data |
| ctrlRdata | output | 32 | Control word with live pointers |
| baseWord | input | 32 | Ring base address bits 39:8 |
| cfgDirOut | input | 1 | 1 = memory to slot, 0 = slot to memory |
| cfgWide | input | 1 | 1 = 16-bit samples, 0 = 8-bit samples |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 40 | Chunk byte address |
| memWdata | output | 256 | Chunk to write |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 256 | Chunk returned with acknowledge |
| slotPull | input | 1 | Slot takes the next output chunk |
| slotData | output | 256 | Chunk presented to the slot |
| slotPush | input | 1 | Slot delivers an input chunk |
| slotInData | input | 256 | Input chunk from the slot |
| trigIrq | output | 1 | Section trigger pulse |
| overflowFlag | output | 1 | Input overflow pulse |
| underflowFlag | output | 1 | Output underflow pulse |

## Verification
memReq and memAddr are combinational from the state, so they are sampled on the falling edge straight after the edge that made them valid. An acknowledge seen at one rising edge moves the pointer, the held chunk and trigIrq at that same edge, so the pointer readback and the interrupt counter are checked one falling edge later. Pulls and pushes are registered: slotData, underflowFlag and overflowFlag are compared on the falling edge that follows the strobe's rising edge. Every stimulus is applied on a falling edge, so no check samples a value in the cycle it changes.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int PTR_W  = 8;
  localparam int SIZE_W = 3;

  // strobes issued by control toward the datapath
  typedef struct packed {
    logic hwAdvance;
    logic ptrClear;
    logic bufLoadMem;
    logic bufLoadSlot;
    logic lastLoad;
  } dmaStrobes_t;
endpackage

// File: rtl/ring_dma_ctrl.sv
module ring_dma_ctrl
  import ring_dma_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic [31:0]         ctrlWdata,
  input  logic                cfgDirOut,
  input  logic [PTR_W-1:0]    hwPtr,
  input  logic                memAck,
  input  logic                slotPull,
  input  logic                slotPush,
  output dmaStrobes_t         stb,
  output logic                memReq,
  output logic [SIZE_W-1:0]   sizeSel,
  output logic                enable,
  output logic [2:0]          tmaskSel,
  output logic [PTR_W-1:0]    trigPtr,
  output logic [PTR_W-1:0]    swPtr,
  output logic [PTR_W-1:0]    ringMask,
  output logic                overflowFlag,
  output logic                underflowFlag
);
  logic bufValid;
  logic wrReset, wrClear, clearAny, xfer, pullOk, pushOk;
  logic [PTR_W-1:0] nextHw;

  assign wrReset  = ctrlWr & ctrlWdata[31];
  assign wrClear  = ctrlWr & ~ctrlWdata[31] & ~ctrlWdata[27] & (ctrlWdata[15:0] == 16'h0);
  assign clearAny = wrReset | wrClear;

  assign ringMask = 8'hFF >> (3'd7 - sizeSel);
  assign nextHw   = (hwPtr + 8'd1) & ringMask;

  always_comb begin
    if (!enable)       memReq = 1'b0;
    else if (cfgDirOut) memReq = ~bufValid & (hwPtr != swPtr);
    else                memReq = bufValid & (nextHw != swPtr);
  end

  assign xfer   = memReq & memAck & ~clearAny;
  assign pullOk = enable & cfgDirOut & slotPull & bufValid & ~clearAny;
  assign pushOk = enable & ~cfgDirOut & slotPush & ~bufValid & ~clearAny;

  always_comb begin
    stb             = '0;
    stb.hwAdvance   = xfer;
    stb.ptrClear    = clearAny;
    stb.bufLoadMem  = xfer & cfgDirOut;
    stb.bufLoadSlot = pushOk;
    stb.lastLoad    = pullOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeSel <= '0; enable <= 1'b0; tmaskSel <= '0;
      trigPtr <= '0; swPtr <= '0; bufValid <= 1'b0;
      overflowFlag <= 1'b0; underflowFlag <= 1'b0;
    end else begin
      overflowFlag  <= enable & ~cfgDirOut & slotPush & bufValid & ~clearAny;
      underflowFlag <= enable & cfgDirOut & slotPull & ~bufValid & ~clearAny;
      if (wrReset) begin
        sizeSel <= '0; enable <= 1'b0; tmaskSel <= '0;
        trigPtr <= '0; swPtr <= '0;
      end else if (ctrlWr) begin
        sizeSel  <= ctrlWdata[30:28];
        enable   <= ctrlWdata[27];
        tmaskSel <= ctrlWdata[26:24];
        trigPtr  <= ctrlWdata[23:16];
        swPtr    <= cfgDirOut ? ctrlWdata[7:0] : ctrlWdata[15:8];
      end
      if (clearAny)                   bufValid <= 1'b0;
      else if (xfer | pushOk)         bufValid <= cfgDirOut ? 1'b1 : ~xfer;
      else if (pullOk)                bufValid <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_dma_datapath.sv
module ring_dma_datapath
  import ring_dma_pkg::*;
#(
  parameter int CHUNK_BYTES = 32,
  parameter int BASE_W      = 32,
  parameter int ADDR_W      = 40,
  localparam int DATA_W      = CHUNK_BYTES * 8,
  localparam int CHUNK_SHIFT = $clog2(CHUNK_BYTES),
  localparam int BASE_SHIFT  = ADDR_W - BASE_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  dmaStrobes_t        stb,
  input  logic [BASE_W-1:0]  baseWord,
  input  logic               cfgDirOut,
  input  logic               cfgWide,
  input  logic               enable,
  input  logic [2:0]         tmaskSel,
  input  logic [PTR_W-1:0]   trigPtr,
  input  logic [PTR_W-1:0]   ringMask,
  input  logic [DATA_W-1:0]  memRdata,
  input  logic [DATA_W-1:0]  slotInData,
  output logic [PTR_W-1:0]   hwPtr,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic [DATA_W-1:0]  slotData,
  output logic               trigIrq
);
  logic [DATA_W-1:0] xorPat, bufData, lastChunk;
  logic [PTR_W-1:0]  nextHw, trigMask;

  for (genvar b = 0; b < CHUNK_BYTES; b++) begin : g_fmt
    assign xorPat[8*b +: 8] = cfgWide ? 8'h00 : 8'h80;
  end

  assign nextHw   = (hwPtr + 8'd1) & ringMask;
  assign trigMask = 8'hFF >> tmaskSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwPtr <= '0; bufData <= '0; lastChunk <= '0; trigIrq <= 1'b0;
    end else if (stb.ptrClear) begin
      hwPtr <= '0; bufData <= '0; lastChunk <= '0; trigIrq <= 1'b0;
    end else begin
      trigIrq <= stb.hwAdvance & ((nextHw & trigMask) == (trigPtr & trigMask));
      if (stb.hwAdvance)   hwPtr     <= nextHw;
      if (stb.bufLoadMem)  bufData   <= memRdata ^ xorPat;
      if (stb.bufLoadSlot) bufData   <= slotInData ^ xorPat;
      if (stb.lastLoad)    lastChunk <= bufData;
    end
  end

  assign memAddr  = {baseWord, {BASE_SHIFT{1'b0}}} + (ADDR_W'(hwPtr) << CHUNK_SHIFT);
  assign memWdata = bufData;
  assign slotData = (enable & cfgDirOut) ? lastChunk : '0;
endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int CHUNK_BYTES = 32,
  parameter int BASE_W      = 32,
  parameter int ADDR_W      = 40,
  localparam int DATA_W     = CHUNK_BYTES * 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [31:0]       ctrlWdata,
  output logic [31:0]       ctrlRdata,
  input  logic [BASE_W-1:0] baseWord,
  input  logic              cfgDirOut,
  input  logic              cfgWide,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              slotPull,
  output logic [DATA_W-1:0] slotData,
  input  logic              slotPush,
  input  logic [DATA_W-1:0] slotInData,
  output logic              trigIrq,
  output logic              overflowFlag,
  output logic              underflowFlag
);
  dmaStrobes_t       stb;
  logic [PTR_W-1:0]  hwPtr, swPtr, trigPtr, ringMask;
  logic [SIZE_W-1:0] sizeSel;
  logic [2:0]        tmaskSel;
  logic              enable;

  ring_dma_ctrl u_ctrl (
    .clk, .rstN, .ctrlWr, .ctrlWdata, .cfgDirOut, .hwPtr, .memAck,
    .slotPull, .slotPush, .stb, .memReq, .sizeSel, .enable, .tmaskSel,
    .trigPtr, .swPtr, .ringMask, .overflowFlag, .underflowFlag
  );

  ring_dma_datapath #(.CHUNK_BYTES(CHUNK_BYTES), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk, .rstN, .stb, .baseWord, .cfgDirOut, .cfgWide, .enable, .tmaskSel,
    .trigPtr, .ringMask, .memRdata, .slotInData, .hwPtr, .memAddr, .memWdata,
    .slotData, .trigIrq
  );

  assign memWrite  = ~cfgDirOut;
  assign ctrlRdata = {1'b0, sizeSel, enable, tmaskSel, trigPtr,
                      cfgDirOut ? hwPtr : swPtr,
                      cfgDirOut ? swPtr : hwPtr};
endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk #(parameter int DATA_W = 256) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWr,
  input logic              cfgDirOut,
  input logic              enBit,
  input logic [7:0]        rdPtr,
  input logic [7:0]        wrPtr,
  input logic              memReq,
  input logic              memWrite,
  input logic              memAck,
  input logic              slotPush,
  input logic [DATA_W-1:0] slotData,
  input logic              trigIrq,
  input logic              overflowFlag,
  input logic              underflowFlag
);
  // R3
  out_ptr_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !ctrlWr && cfgDirOut) |=> (rdPtr != $past(rdPtr)));
  // R4
  in_ptr_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && !ctrlWr && !cfgDirOut) |=> (wrPtr != $past(wrPtr)));
  // R4
  req_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memWrite != cfgDirOut));
  // R11
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |-> !memReq);
  // R7
  trig_after_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigIrq |-> $past(memReq && memAck));
  // R8
  underflow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflowFlag && !$past(ctrlWr)) |-> $stable(slotData));
  // R9
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |-> $past(slotPush));
endmodule

bind ring_dma_chan ring_dma_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .cfgDirOut(cfgDirOut),
  .enBit(ctrlRdata[27]), .rdPtr(ctrlRdata[15:8]), .wrPtr(ctrlRdata[7:0]),
  .memReq(memReq), .memWrite(memWrite), .memAck(memAck), .slotPush(slotPush),
  .slotData(slotData), .trigIrq(trigIrq), .overflowFlag(overflowFlag),
  .underflowFlag(underflowFlag)
);

// File: tb/sim_ring_dma_chan.sv
module sim_ring_dma_chan;
  localparam int DW = 256;
  localparam logic [DW-1:0] XB = {32{8'h80}};
  // {mask select, trigger pointer, expected pulses over advances 1..16}
  localparam logic [18:0] TRIG_VEC [7] = '{
    {3'd7, 8'h00, 8'd8}, {3'd6, 8'h01, 8'd4}, {3'd5, 8'h03, 8'd2},
    {3'd4, 8'h10, 8'd1}, {3'd0, 8'h05, 8'd1}, {3'd0, 8'h20, 8'd0},
    {3'd3, 8'h2A, 8'd1}};

  logic clk = 0, rstN = 0;
  logic ctrlWr = 0; logic [31:0] ctrlWdata = 0, ctrlRdata;
  logic [31:0] baseWord = 32'h0000_1234;
  logic cfgDirOut = 1, cfgWide = 0;
  logic memReq, memWrite, memAck = 0;
  logic [39:0] memAddr;
  logic [DW-1:0] memWdata, memRdata = '0, slotData, slotInData = '0;
  logic slotPull = 0, slotPush = 0;
  logic trigIrq, overflowFlag, underflowFlag;
  logic [DW-1:0] mem [256];
  int checks = 0, errors = 0, irqCnt = 0;

  always #10 clk = ~clk;

  ring_dma_chan u0 (.*);

  // memory responder: acknowledges one half cycle after a request appears
  always @(negedge clk) begin
    logic [7:0] idx;
    idx = 8'((memAddr - {baseWord, 8'h00}) >> 5);
    memAck = memReq;
    if (memReq && !memWrite) memRdata = mem[idx];
    if (memReq && memWrite)  mem[idx] = memWdata;
  end

  always @(negedge clk) if (trigIrq) irqCnt++;

  function automatic logic [DW-1:0] pat(int i);
    logic [DW-1:0] r;
    for (int j = 0; j < 32; j++) r[8*j +: 8] = 8'(i*13 + j*5 + 1);
    return r;
  endfunction

  function automatic logic [31:0] cw(int sz, int en, int tm, int tp, int rd, int wr);
    return {1'b0, 3'(sz), 1'(en), 3'(tm), 8'(tp), 8'(rd), 8'(wr)};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrlWrite(input logic [31:0] d);
    @(negedge clk); ctrlWr = 1; ctrlWdata = d;
    @(negedge clk); ctrlWr = 0;
  endtask

  task automatic pull();
    repeat (3) @(negedge clk);
    slotPull = 1;
    @(negedge clk); slotPull = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    repeat (3) @(negedge clk);
    slotPush = 1; slotInData = d;
    @(negedge clk); slotPush = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", DW'(ctrlRdata), '0);
    check("R1 req", DW'(memReq), '0);
    check("R1 slot", slotData, '0);
    check("R1 flags", DW'({trigIrq, overflowFlag, underflowFlag}), '0);

    // R11 and R2: disabled channel, hardware field of a write ignored
    ctrlWrite(32'h7000_0904);
    repeat (3) @(negedge clk);
    check("R11 no req", DW'(memReq), '0);
    check("R2 readback", DW'(ctrlRdata), DW'(32'h7000_0004));
    pull();
    check("R11 pull ignored", DW'({underflowFlag, |slotData}), '0);

    // R7 trigger table, output direction, 8-bit
    for (int v = 0; v < 7; v++) begin
      int startCnt;
      ctrlWrite(32'h8000_0000);
      ctrlWrite(cw(7, 1, TRIG_VEC[v][18:16], TRIG_VEC[v][15:8], 0, 16));
      startCnt = irqCnt;
      for (int k = 0; k < 16; k++) pull();
      repeat (3) @(negedge clk);
      check($sformatf("R7 vector %0d pulses", v), DW'(irqCnt - startCnt), DW'(TRIG_VEC[v][7:0]));
      check("R5 8-bit out data", slotData, pat(15) ^ XB);
    end

    // R3 addressing and R8 underflow
    ctrlWrite(32'h8000_0000);
    ctrlWrite(cw(7, 1, 0, 0, 0, 3));
    check("R3 addr0", DW'({memReq, memWrite, memAddr}), DW'({1'b1, 1'b0, 40'h12_3400}));
    repeat (2) @(negedge clk);
    check("R3 rd ptr", DW'(ctrlRdata[15:8]), DW'(1));
    cfgWide = 1;
    pull();
    check("R3 addr1", DW'(memAddr), DW'(40'h12_3420));
    check("R8 first chunk", slotData, pat(0) ^ XB);
    pull();
    check("R5 16-bit passes", slotData, pat(1));
    pull();
    pull();
    check("R8 underflow", DW'(underflowFlag), DW'(1));
    check("R8 repeat last", slotData, pat(2));

    // R8 zeros when disabled, R10 clear
    ctrlWrite(cw(7, 0, 0, 0, 0, 3));
    check("R8 disabled zero", slotData, '0);
    ctrlWrite(cw(7, 0, 0, 0, 0, 0));
    check("R10 cleared", DW'(ctrlRdata), DW'(32'h7000_0000));
    ctrlWrite(cw(7, 1, 0, 0, 0, 1));
    pull();
    check("R10 restart at chunk 0", slotData, pat(0));

    // R6 wrap with an 8-chunk ring
    ctrlWrite(32'h8000_0000);
    ctrlWrite(cw(2, 1, 0, 0, 0, 6));
    for (int k = 0; k < 6; k++) pull();
    ctrlWrite(cw(2, 1, 0, 0, 0, 2));
    pull(); pull(); pull();
    check("R6 wrapped chunk", slotData, pat(0));
    pull();
    repeat (2) @(negedge clk);
    check("R6 rd ptr wrapped", DW'(ctrlRdata[15:8]), DW'(2));

    // R4 input direction, R9 overflow
    ctrlWrite(32'h8000_0000);
    cfgDirOut = 0; cfgWide = 0;
    ctrlWrite(cw(2, 1, 0, 0, 0, 0));
    push(pat(100));
    check("R4 write req", DW'({memReq, memWrite, memAddr}), DW'({1'b1, 1'b1, 40'h12_3400}));
    repeat (2) @(negedge clk);
    check("R4 stored", mem[0], pat(100) ^ XB);
    check("R4 wr ptr", DW'(ctrlRdata[7:0]), DW'(1));
    for (int k = 1; k < 8; k++) push(pat(100 + k));
    repeat (3) @(negedge clk);
    check("R4 full stall ptr", DW'(ctrlRdata[7:0]), DW'(7));
    check("R4 full no req", DW'(memReq), '0);
    push(pat(200));
    check("R9 overflow", DW'(overflowFlag), DW'(1));
    ctrlWrite(cw(2, 1, 0, 0, 3, 0));
    repeat (3) @(negedge clk);
    check("R9 held chunk kept", mem[7], pat(107) ^ XB);
    check("R6 wr ptr wrapped", DW'(ctrlRdata[7:0]), DW'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule